// File: doc/BRIEF.md
# Display Bridge Power-Up Sequencer

This block brings an external display-link bridge out of power-down, waits out the bridge's unreliable boot period, confirms the downstream link, and only then turns on the panel backlight. It drives the bridge's active-low power-down and reset lines, watches an active-high hot-plug-detect (HPD) input through a two-flop synchronizer, and hands link training to an external controller through a start pulse and done/fail responses. Supply switches on the power management side are requested with one-cycle enable pulses.

After a start request the block pulses the panel logic supply enable and polls HPD until it reads low. It then runs a short bridge reset and begins up to a bounded number of attempts. Each attempt ignores HPD for a fixed settle window, which hides a spurious high that the bridge raises while it boots, and samples HPD once at the end of that window. A low sample forces a long full bridge reset before the next attempt; a link failure retries at once. After a good link the backlight supply, the constant-high PWM output and the backlight enable follow with fixed gaps. Every delay is given in milliseconds or microseconds and turned into clock cycles through a clock-frequency parameter.

Top module: `disp_bridge_seq`

## Requirements
- R1: While and after synchronous reset, bridge_pd_n_o and bridge_rst_n_o are 1, every enable, pulse, done_o and error_o is 0, attempt_o is 0 and state_o is 0 (idle).
- R2: A start_i sampled high in idle gives a panel_vdd_en_o pulse of exactly one cycle, high in the cycle after that edge.
- R3: While the synchronized HPD reads high in the polling phase, the bridge lines stay high and the sequence does not advance; it advances on the first poll that reads low.
- R4: Bridge setup holds bridge_rst_n_o low with bridge_pd_n_o high for exactly the setup count, then drives both high and attempt_o becomes 1.
- R5: HPD is sampled exactly the settle count of cycles after an attempt starts and any level before that point is ignored; a high sample gives a one-cycle link_start_o pulse at that point.
- R6: A low sample at the end of the settle window drives both bridge lines low for exactly the reset count, after which both go high and attempt_o increments.
- R7: A link_fail_i sampled high while waiting for the link starts the next attempt on that edge, with no bridge reset, and attempt_o increments; attempt_o never exceeds MAX_TRIES.
- R8: When the last allowed attempt fails (after its bridge reset, or on link failure) error_o goes high and stays high, and no backlight output is ever asserted in that run.
- R9: A link_done_i sampled high gives a one-cycle bl_vdd_en_o pulse T3 cycles later, bl_pwm_o high T5 cycles after that pulse, then bl_en_o and done_o high T6 cycles later; each level stays.
- R10: Each delay count is ceil(CLK_HZ x microseconds / 1000000) with a minimum of 1, and every timed phase lasts exactly its count.
- R11: start_i has no effect once the sequence has left idle, including after done or error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin the power-up sequence |
| hpd_i | input | 1 | Hot-plug detect from the bridge, active high, asynchronous |
| link_done_i | input | 1 | Link controller reports success |
| link_fail_i | input | 1 | Link controller reports failure |
| link_start_o | output | 1 | One-cycle pulse starting link training |
| panel_vdd_en_o | output | 1 | One-cycle request to switch on the panel logic supply |
| bl_vdd_en_o | output | 1 | One-cycle request to switch on the backlight supply |
| bridge_pd_n_o | output | 1 | Bridge power-down, active low |
| bridge_rst_n_o | output | 1 | Bridge reset, active low |
| bl_pwm_o | output | 1 | Backlight PWM, held high for full brightness |
| bl_en_o | output | 1 | Backlight enable |
| done_o | output | 1 | Sequence finished with the backlight on |
| error_o | output | 1 | Sticky failure after all attempts |
| attempt_o | output | 3 | Number of the current attempt |
| state_o | output | 4 | Sequencer state code, 0 is idle |

## Verification
The bench builds the block with CLK_HZ set to 10000, so one cycle is 100 us: the poll and setup delays round up to one cycle, the settle window is 900 cycles, the full reset 3000 cycles and the backlight gaps 600, 100 and 100 cycles. At that rate a run of five attempts, each with the long reset, stays near twenty thousand cycles, so exhausting every retry, mixing bad HPD samples with link failures, and placing a spurious HPD high inside each settle window all fit in one short run while every phase length is still checked to the exact cycle.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_HPD_WAIT = 4'd1,
        ST_SETUP    = 4'd2,
        ST_SETTLE   = 4'd3,
        ST_LINK     = 4'd4,
        ST_RESET    = 4'd5,
        ST_GAP_SUP  = 4'd6,
        ST_GAP_PWM  = 4'd7,
        ST_GAP_EN   = 4'd8,
        ST_DONE     = 4'd9,
        ST_ERROR    = 4'd10
    } seq_state_e;

    typedef struct packed {
        logic       pd_n;
        logic       rst_n;
        logic       panel_en;
        logic       link_start;
        logic       bl_vdd;
        logic       bl_pwm;
        logic       bl_en;
        logic       done;
        logic       err;
        logic [2:0] attempt;
    } seq_ctl_t;

    localparam seq_ctl_t CTL_IDLE = '{
        pd_n: 1'b1, rst_n: 1'b1, panel_en: 1'b0, link_start: 1'b0,
        bl_vdd: 1'b0, bl_pwm: 1'b0, bl_en: 1'b0, done: 1'b0,
        err: 1'b0, attempt: 3'd0
    };

    // Cycles for a delay in microseconds, rounded up, never below one.
    function automatic longint unsigned us_to_cycles(longint unsigned hz,
                                                     longint unsigned us);
        longint unsigned c;
        c = (hz * us + 64'd999_999) / 64'd1_000_000;
        return (c == 64'd0) ? 64'd1 : c;
    endfunction

    function automatic longint unsigned ms_to_cycles(longint unsigned hz,
                                                     longint unsigned ms);
        return us_to_cycles(hz, ms * 64'd1000);
    endfunction

    function automatic longint unsigned lmax(longint unsigned a,
                                             longint unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dbs_sync.sv
module dbs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], d_i};
    end

    assign q_o = sr[STAGES-1];
endmodule

// File: rtl/dbs_timer.sv
module dbs_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [TW-1:0] val_i,
    output logic          expired_o
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load_i)      cnt <= val_i;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired_o = (cnt == '0);
endmodule

// File: rtl/dbs_fsm.sv
module dbs_fsm
    import dbs_pkg::*;
#(
    parameter int              TW        = 16,
    parameter int              MAX_TRIES = 5,
    parameter longint unsigned C_POLL    = 1,
    parameter longint unsigned C_SETUP   = 1,
    parameter longint unsigned C_SETTLE  = 1,
    parameter longint unsigned C_RESET   = 1,
    parameter longint unsigned C_GAP_SUP = 1,
    parameter longint unsigned C_GAP_PWM = 1,
    parameter longint unsigned C_GAP_EN  = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          hpd_s_i,
    input  logic          link_done_i,
    input  logic          link_fail_i,
    input  logic          tmr_exp_i,
    output logic          tmr_ld_o,
    output logic [TW-1:0] tmr_val_o,
    output seq_ctl_t      ctl_o,
    output logic [3:0]    state_o
);
    // Timer is loaded with count-1 so that a phase lasts exactly count cycles.
    localparam logic [TW-1:0] L_POLL    = TW'(C_POLL - 1);
    localparam logic [TW-1:0] L_SETUP   = TW'(C_SETUP - 1);
    localparam logic [TW-1:0] L_SETTLE  = TW'(C_SETTLE - 1);
    localparam logic [TW-1:0] L_RESET   = TW'(C_RESET - 1);
    localparam logic [TW-1:0] L_GAP_SUP = TW'(C_GAP_SUP - 1);
    localparam logic [TW-1:0] L_GAP_PWM = TW'(C_GAP_PWM - 1);
    localparam logic [TW-1:0] L_GAP_EN  = TW'(C_GAP_EN - 1);
    localparam logic [2:0]    LAST_TRY  = 3'(MAX_TRIES);

    seq_state_e st, st_nx;
    seq_ctl_t   ctl, ctl_nx;

    always_comb begin
        st_nx             = st;
        ctl_nx            = ctl;
        ctl_nx.panel_en   = 1'b0;
        ctl_nx.link_start = 1'b0;
        ctl_nx.bl_vdd     = 1'b0;
        tmr_ld_o          = 1'b0;
        tmr_val_o         = '0;
        unique case (st)
            ST_IDLE: if (start_i) begin
                st_nx           = ST_HPD_WAIT;
                ctl_nx.panel_en = 1'b1;
                tmr_ld_o        = 1'b1;
                tmr_val_o       = L_POLL;
            end
            ST_HPD_WAIT: if (tmr_exp_i) begin
                tmr_ld_o = 1'b1;
                if (!hpd_s_i) begin
                    st_nx        = ST_SETUP;
                    ctl_nx.pd_n  = 1'b1;
                    ctl_nx.rst_n = 1'b0;
                    tmr_val_o    = L_SETUP;
                end else begin
                    tmr_val_o    = L_POLL;
                end
            end
            ST_SETUP: if (tmr_exp_i) begin
                st_nx          = ST_SETTLE;
                ctl_nx.rst_n   = 1'b1;
                ctl_nx.pd_n    = 1'b1;
                ctl_nx.attempt = 3'd1;
                tmr_ld_o       = 1'b1;
                tmr_val_o      = L_SETTLE;
            end
            ST_SETTLE: if (tmr_exp_i) begin
                if (hpd_s_i) begin
                    st_nx             = ST_LINK;
                    ctl_nx.link_start = 1'b1;
                end else begin
                    st_nx        = ST_RESET;
                    ctl_nx.pd_n  = 1'b0;
                    ctl_nx.rst_n = 1'b0;
                    tmr_ld_o     = 1'b1;
                    tmr_val_o    = L_RESET;
                end
            end
            ST_LINK: begin
                if (link_fail_i) begin
                    if (ctl.attempt == LAST_TRY) begin
                        st_nx      = ST_ERROR;
                        ctl_nx.err = 1'b1;
                    end else begin
                        st_nx          = ST_SETTLE;
                        ctl_nx.attempt = ctl.attempt + 3'd1;
                        tmr_ld_o       = 1'b1;
                        tmr_val_o      = L_SETTLE;
                    end
                end else if (link_done_i) begin
                    st_nx     = ST_GAP_SUP;
                    tmr_ld_o  = 1'b1;
                    tmr_val_o = L_GAP_SUP;
                end
            end
            ST_RESET: if (tmr_exp_i) begin
                if (ctl.attempt == LAST_TRY) begin
                    st_nx      = ST_ERROR;
                    ctl_nx.err = 1'b1;
                end else begin
                    st_nx          = ST_SETTLE;
                    ctl_nx.pd_n    = 1'b1;
                    ctl_nx.rst_n   = 1'b1;
                    ctl_nx.attempt = ctl.attempt + 3'd1;
                    tmr_ld_o       = 1'b1;
                    tmr_val_o      = L_SETTLE;
                end
            end
            ST_GAP_SUP: if (tmr_exp_i) begin
                st_nx         = ST_GAP_PWM;
                ctl_nx.bl_vdd = 1'b1;
                tmr_ld_o      = 1'b1;
                tmr_val_o     = L_GAP_PWM;
            end
            ST_GAP_PWM: if (tmr_exp_i) begin
                st_nx         = ST_GAP_EN;
                ctl_nx.bl_pwm = 1'b1;
                tmr_ld_o      = 1'b1;
                tmr_val_o     = L_GAP_EN;
            end
            ST_GAP_EN: if (tmr_exp_i) begin
                st_nx        = ST_DONE;
                ctl_nx.bl_en = 1'b1;
                ctl_nx.done  = 1'b1;
            end
            ST_DONE, ST_ERROR: begin
            end
            default: begin
                st_nx  = ST_IDLE;
                ctl_nx = CTL_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            ctl <= CTL_IDLE;
        end else begin
            st  <= st_nx;
            ctl <= ctl_nx;
        end
    end

    assign ctl_o   = ctl;
    assign state_o = st;
endmodule

// File: rtl/disp_bridge_seq.sv
module disp_bridge_seq
    import dbs_pkg::*;
#(
    parameter longint unsigned CLK_HZ     = 100_000_000,
    parameter longint unsigned POLL_US    = 50,
    parameter longint unsigned SETUP_US   = 10,
    parameter longint unsigned SETTLE_MS  = 90,
    parameter longint unsigned RESET_MS   = 300,
    parameter longint unsigned GAP_SUP_MS = 60,
    parameter longint unsigned GAP_PWM_MS = 10,
    parameter longint unsigned GAP_EN_MS  = 10,
    parameter int              MAX_TRIES  = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       hpd_i,
    input  logic       link_done_i,
    input  logic       link_fail_i,
    output logic       link_start_o,
    output logic       panel_vdd_en_o,
    output logic       bl_vdd_en_o,
    output logic       bridge_pd_n_o,
    output logic       bridge_rst_n_o,
    output logic       bl_pwm_o,
    output logic       bl_en_o,
    output logic       done_o,
    output logic       error_o,
    output logic [2:0] attempt_o,
    output logic [3:0] state_o
);
    localparam longint unsigned C_POLL    = us_to_cycles(CLK_HZ, POLL_US);
    localparam longint unsigned C_SETUP   = us_to_cycles(CLK_HZ, SETUP_US);
    localparam longint unsigned C_SETTLE  = ms_to_cycles(CLK_HZ, SETTLE_MS);
    localparam longint unsigned C_RESET   = ms_to_cycles(CLK_HZ, RESET_MS);
    localparam longint unsigned C_GAP_SUP = ms_to_cycles(CLK_HZ, GAP_SUP_MS);
    localparam longint unsigned C_GAP_PWM = ms_to_cycles(CLK_HZ, GAP_PWM_MS);
    localparam longint unsigned C_GAP_EN  = ms_to_cycles(CLK_HZ, GAP_EN_MS);
    localparam longint unsigned C_MAX =
        lmax(lmax(lmax(C_POLL, C_SETUP), lmax(C_SETTLE, C_RESET)),
             lmax(lmax(C_GAP_SUP, C_GAP_PWM), C_GAP_EN));
    localparam int TW = (C_MAX < 2) ? 1 : $clog2(C_MAX);

    logic          hpd_s;
    logic          tmr_ld, tmr_exp;
    logic [TW-1:0] tmr_val;
    seq_ctl_t      ctl;

    dbs_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d_i(hpd_i), .q_o(hpd_s)
    );

    dbs_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst(rst), .load_i(tmr_ld), .val_i(tmr_val),
        .expired_o(tmr_exp)
    );

    dbs_fsm #(
        .TW(TW), .MAX_TRIES(MAX_TRIES),
        .C_POLL(C_POLL), .C_SETUP(C_SETUP), .C_SETTLE(C_SETTLE),
        .C_RESET(C_RESET), .C_GAP_SUP(C_GAP_SUP), .C_GAP_PWM(C_GAP_PWM),
        .C_GAP_EN(C_GAP_EN)
    ) u_fsm (
        .clk(clk), .rst(rst), .start_i(start_i), .hpd_s_i(hpd_s),
        .link_done_i(link_done_i), .link_fail_i(link_fail_i),
        .tmr_exp_i(tmr_exp), .tmr_ld_o(tmr_ld), .tmr_val_o(tmr_val),
        .ctl_o(ctl), .state_o(state_o)
    );

    assign link_start_o   = ctl.link_start;
    assign panel_vdd_en_o = ctl.panel_en;
    assign bl_vdd_en_o    = ctl.bl_vdd;
    assign bridge_pd_n_o  = ctl.pd_n;
    assign bridge_rst_n_o = ctl.rst_n;
    assign bl_pwm_o       = ctl.bl_pwm;
    assign bl_en_o        = ctl.bl_en;
    assign done_o         = ctl.done;
    assign error_o        = ctl.err;
    assign attempt_o      = ctl.attempt;
endmodule

// File: rtl/disp_bridge_seq_chk.sv
module disp_bridge_seq_chk #(
    parameter int MAX_TRIES = 5
) (
    input logic       clk,
    input logic       rst,
    input logic       link_start_o,
    input logic       panel_vdd_en_o,
    input logic       bl_vdd_en_o,
    input logic       bridge_pd_n_o,
    input logic       bridge_rst_n_o,
    input logic       bl_pwm_o,
    input logic       bl_en_o,
    input logic       done_o,
    input logic       error_o,
    input logic [2:0] attempt_o,
    input logic [3:0] state_o
);
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (bridge_pd_n_o && bridge_rst_n_o && !bl_en_o && !bl_pwm_o
                        && !done_o && !error_o && attempt_o == 3'd0 && state_o == 4'd0));

    assert_panel_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        panel_vdd_en_o |=> !panel_vdd_en_o);

    assert_setup_first_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(bridge_rst_n_o) && bridge_pd_n_o) |-> attempt_o == 3'd0);

    assert_link_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        link_start_o |=> !link_start_o);

    assert_reset_pair_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(bridge_pd_n_o) |-> !bridge_rst_n_o);

    assert_attempt_cap_R7: assert property (@(posedge clk) disable iff (rst)
        attempt_o <= 3'(MAX_TRIES));

    assert_error_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        error_o |=> error_o);

    assert_error_no_light_R8: assert property (@(posedge clk) disable iff (rst)
        error_o |-> (!bl_vdd_en_o && !bl_pwm_o && !bl_en_o && !done_o));

    assert_en_after_pwm_R9: assert property (@(posedge clk) disable iff (rst)
        bl_en_o |-> bl_pwm_o);

    assert_done_with_en_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> bl_en_o);

    assert_done_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (done_o && !panel_vdd_en_o));
endmodule

bind disp_bridge_seq disp_bridge_seq_chk #(.MAX_TRIES(MAX_TRIES)) u_chk (
    .clk(clk), .rst(rst), .link_start_o(link_start_o),
    .panel_vdd_en_o(panel_vdd_en_o), .bl_vdd_en_o(bl_vdd_en_o),
    .bridge_pd_n_o(bridge_pd_n_o), .bridge_rst_n_o(bridge_rst_n_o),
    .bl_pwm_o(bl_pwm_o), .bl_en_o(bl_en_o), .done_o(done_o),
    .error_o(error_o), .attempt_o(attempt_o), .state_o(state_o)
);

// File: tb/disp_bridge_seq_tb.sv
module disp_bridge_seq_tb;
    localparam longint unsigned HZ = 10_000;
    localparam int TRIES = 5;

    function automatic longint cyc_of(longint unsigned us);
        longint unsigned c;
        c = (HZ * us + 64'd999_999) / 64'd1_000_000;
        return (c == 0) ? 1 : longint'(c);
    endfunction

    localparam longint N_SETUP  = cyc_of(10);
    localparam longint N_SETTLE = cyc_of(90_000);
    localparam longint N_RESET  = cyc_of(300_000);
    localparam longint N_T3     = cyc_of(60_000);
    localparam longint N_T5     = cyc_of(10_000);
    localparam longint N_T6     = cyc_of(10_000);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, hpd_i = 1'b0, link_done_i = 1'b0, link_fail_i = 1'b0;
    logic link_start_o, panel_vdd_en_o, bl_vdd_en_o, bridge_pd_n_o, bridge_rst_n_o;
    logic bl_pwm_o, bl_en_o, done_o, error_o;
    logic [2:0] attempt_o;
    logic [3:0] state_o;

    int tests = 0, fails = 0;
    longint cyc = 0;
    int bl_cnt = 0;
    int plan [0:4];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (bl_vdd_en_o || bl_pwm_o || bl_en_o) bl_cnt <= bl_cnt + 1;

    disp_bridge_seq #(.CLK_HZ(HZ), .MAX_TRIES(TRIES)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .hpd_i(hpd_i),
        .link_done_i(link_done_i), .link_fail_i(link_fail_i),
        .link_start_o(link_start_o), .panel_vdd_en_o(panel_vdd_en_o),
        .bl_vdd_en_o(bl_vdd_en_o), .bridge_pd_n_o(bridge_pd_n_o),
        .bridge_rst_n_o(bridge_rst_n_o), .bl_pwm_o(bl_pwm_o), .bl_en_o(bl_en_o),
        .done_o(done_o), .error_o(error_o), .attempt_o(attempt_o), .state_o(state_o)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        repeat (190_000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic run();
        longint a, f, c, v, p;
        int bl0, last_ok;
        rst = 1'b1; start_i = 1'b0; hpd_i = 1'b1; link_done_i = 1'b0; link_fail_i = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 lines/outputs in reset",
            {bridge_pd_n_o, bridge_rst_n_o, bl_en_o, bl_pwm_o, done_o, error_o, panel_vdd_en_o, link_start_o},
            8'b1100_0000);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 attempt/state after reset", {attempt_o, state_o}, 7'd0);
        bl0 = bl_cnt;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 panel supply pulse", panel_vdd_en_o, 1);
        @(negedge clk);
        chk("R2 panel pulse one cycle", panel_vdd_en_o, 0);
        repeat (4) @(negedge clk);
        start_i = 1'b1;           // R11: ignored while polling
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        chk("R11 start ignored while busy", panel_vdd_en_o, 0);
        chk("R3 bridge untouched while HPD high", {bridge_pd_n_o, bridge_rst_n_o}, 2'b11);
        hpd_i = 1'b0;
        while (bridge_rst_n_o) @(negedge clk);
        chk("R4 power-down high during setup", bridge_pd_n_o, 1);
        f = cyc;
        while (!bridge_rst_n_o) @(negedge clk);
        chk("R4 setup length", cyc - f, N_SETUP);
        chk("R4 first attempt", attempt_o, 1);
        a = cyc;
        last_ok = 0;
        for (int k = 0; k < TRIES; k++) begin
            // spurious high early in the settle window (R5)
            repeat (3) @(negedge clk);
            hpd_i = 1'b1;
            repeat (100 + $urandom % 100) @(negedge clk);
            hpd_i = 1'b0;
            repeat (200) @(negedge clk);
            if (plan[k] != 0) hpd_i = 1'b1;
            if (k == 1) begin
                start_i = 1'b1; @(negedge clk); start_i = 1'b0;   // R11
            end
            if (plan[k] == 0) begin
                while (bridge_rst_n_o) @(negedge clk);
                chk("R6 reset at settle end", cyc - a, N_SETTLE);
                chk("R6 both lines low", {bridge_pd_n_o, link_start_o}, 0);
                f = cyc;
                if (k == TRIES - 1) begin
                    while (!error_o) @(negedge clk);
                    chk("R8 error after last reset", cyc - f, N_RESET);
                end else begin
                    while (!bridge_rst_n_o) @(negedge clk);
                    chk("R6 reset length", cyc - f, N_RESET);
                    chk("R6 power-down released", bridge_pd_n_o, 1);
                    chk("R6 attempt incremented", attempt_o, k + 2);
                    a = cyc;
                end
            end else begin
                while (!link_start_o) @(negedge clk);
                chk("R5 HPD sampled at settle end", cyc - a, N_SETTLE);
                @(negedge clk);
                chk("R5 link start one cycle", link_start_o, 0);
                repeat ($urandom % 20) @(negedge clk);
                if (plan[k] == 1) link_fail_i = 1'b1; else link_done_i = 1'b1;
                c = cyc;
                @(negedge clk);
                link_fail_i = 1'b0; link_done_i = 1'b0;
                hpd_i = 1'b0;
                if (plan[k] == 1) begin
                    if (k == TRIES - 1) begin
                        chk("R8 error on last link failure", error_o, 1);
                    end else begin
                        chk("R7 attempt incremented", attempt_o, k + 2);
                        chk("R7 no bridge reset", {bridge_pd_n_o, bridge_rst_n_o}, 2'b11);
                        a = cyc;
                    end
                end else begin
                    while (!bl_vdd_en_o) @(negedge clk);
                    chk("R9 backlight supply after T3", cyc - (c + 1), N_T3);
                    chk("R9 pwm/en still off", {bl_pwm_o, bl_en_o}, 0);
                    v = cyc;
                    @(negedge clk);
                    chk("R9 supply pulse one cycle", bl_vdd_en_o, 0);
                    while (!bl_pwm_o) @(negedge clk);
                    chk("R9 pwm after T5", cyc - v, N_T5);
                    p = cyc;
                    while (!bl_en_o) @(negedge clk);
                    chk("R9 enable after T6", cyc - p, N_T6);
                    chk("R9 done with enable", done_o, 1);
                    last_ok = 1;
                end
            end
            if (last_ok != 0 || error_o) break;
        end
        if (last_ok != 0) begin
            chk("R9 no error on success", error_o, 0);
        end else begin
            chk("R8 error raised", error_o, 1);
            chk("R8 no backlight in failed run", bl_cnt - bl0, 0);
            chk("R7 attempts used", attempt_o, TRIES);
        end
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 start ignored at end", {panel_vdd_en_o, done_o, error_o, attempt_o},
            {1'b0, last_ok[0], ~last_ok[0], attempt_o});
        chk("R11 end state held", {done_o, error_o}, last_ok != 0 ? 2'b10 : 2'b01);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        chk("R10 settle count", N_SETTLE, 900);
        chk("R10 minimum one cycle", N_SETUP, 1);
        plan = '{2, 2, 2, 2, 2};  run();   // first try good
        plan = '{0, 1, 2, 2, 2};  run();   // bad HPD, link fail, then good
        plan = '{1, 1, 1, 1, 1};  run();   // every link fails
        plan = '{0, 0, 1, 0, 0};  run();   // mixed, ends with reset path
        for (int r = 0; r < 3; r++) begin
            for (int k = 0; k < 5; k++) begin
                int x;
                x = $urandom % 8;
                plan[k] = (x == 0) ? 0 : (x < 4) ? 1 : 2;
            end
            run();
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule